// File: doc/BRIEF.md
# Sector Fill and Prefetch Sequencer

This block sequences refills for an instruction cache whose sectors each hold two lines under one shared tag. The fetch unit hands it a missing line address and a flag that says whether the sector tag is already present. If the tag is present, only the missing line is fetched. If it is absent, the sector is replaced: the block clears both line-valid bits, writes the new tag, and fetches the demanded line. It then prefetches the other line only when the demanded line sat in the lower half of the sector, so prefetch only ever runs forward.

Memory sees one burst at a time through a request/acknowledge pair. While a burst is outstanding the block drives the array write enable and the half being written. A line's valid bit is set only after its burst has been acknowledged. The fetch unit is released as soon as the demanded line is valid, so a prefetch can still be running when that happens. A new miss is held off until any running prefetch has finished.

Top module: `sector_fill_seq`

## Requirements
- R1: After reset, missReady is 1, and memReq, fillWe, validSet, missDone, tagWrite and validClr are all 0.
- R2: A miss accepted with missSectorHit=1 produces no tagWrite or validClr and causes exactly one burst, for the demanded line. No prefetch follows, whichever half the line is in.
- R3: A miss accepted with missSectorHit=0 pulses tagWrite and validClr in the accepting cycle. A miss is accepted when missValid and missReady are both 1. Memory traffic starts only in the next cycle.
- R4: The cycle after acceptance, memReq is 1 and memLine equals the requested line address. fillWe is 1 and fillLine equals bit 0 of that address. Bit 0 selects the half of the sector: 0 is the lower half and 1 is the upper half.
- R5: validSet pulses for one cycle, in the cycle after the one in which memAck is sampled high with memReq high. validLine names the half of the line that completed. validSet never pulses without a preceding acknowledge.
- R6: missDone pulses in the same cycle as the demanded line's validSet.
- R7: For a sector replacement whose demanded line has bit 0 = 0, a prefetch burst follows in the cycle after missDone. Its memLine is the demanded address with bit 0 set to 1, and it ends with validSet and validLine=1.
- R8: For a sector replacement whose demanded line has bit 0 = 1, no burst follows missDone. No backward prefetch is issued.
- R9: missReady is 0 from acceptance until the sequence (including any prefetch) ends. A miss raised during a prefetch is accepted only after the prefetch's validSet.
- R10: While memReq is 1 and memAck is 0, memReq and memLine hold their values in the next cycle. memReq is 0 in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Fetch unit presents a miss |
| missLine | input | LINE_AW | Line address of the miss; bit 0 selects the half of the sector |
| missSectorHit | input | 1 | Sector tag for this address is already present |
| missReady | output | 1 | Sequencer can accept a miss this cycle |
| missDone | output | 1 | Demanded line has become valid |
| memReq | output | 1 | Burst request to memory, held until acknowledged |
| memLine | output | LINE_AW | Line address of the burst in progress |
| memAck | input | 1 | Burst completed |
| fillWe | output | 1 | Array write enable for the line being filled |
| fillLine | output | 1 | Half of the sector being written |
| validSet | output | 1 | Set one line-valid bit |
| validLine | output | 1 | Half whose valid bit is set |
| tagWrite | output | 1 | Write new sector tag taken from missLine |
| validClr | output | 1 | Clear both valid bits of the sector addressed by missLine |

## Verification
The assertions assume that memAck is raised only while memReq is high and for one cycle per burst. They also assume that missLine and missSectorHit are steady whenever missValid is high. The bench raises the acknowledge for a single cycle, always inside an outstanding burst, after a chosen wait of zero to several cycles. It holds a pending miss unchanged until the sequencer takes it, including the case where the miss is raised in the middle of a prefetch.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL_DEMAND,
    ST_FILL_PREFETCH,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;     // miss accepted this cycle
    logic newSector;   // accepted miss replaces the sector
    logic burstOn;     // a burst is outstanding
    logic selPref;     // outstanding burst is the prefetch
    logic doneDemand;  // demanded burst acknowledged
    logic donePref;    // prefetch burst acknowledged
  } seqStrobe_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       missSectorHit,
  input  logic       missLineBit,
  input  logic       memAck,
  output seqStrobe_t strb,
  output logic       missReady,
  output logic       memReq,
  output logic       missDone
);
  seqState_t stateQ, stateD;
  logic      prefPendQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:          if (missValid) stateD = ST_FILL_DEMAND;
      ST_FILL_DEMAND:   if (memAck)    stateD = ST_DONE;
      ST_DONE:          stateD = prefPendQ ? ST_FILL_PREFETCH : ST_IDLE;
      ST_FILL_PREFETCH: if (memAck)    stateD = ST_IDLE;
      default:          stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      prefPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.capture) prefPendQ <= !missSectorHit && !missLineBit;
    end
  end

  assign missReady = (stateQ == ST_IDLE);
  assign memReq    = (stateQ == ST_FILL_DEMAND) || (stateQ == ST_FILL_PREFETCH);
  assign missDone  = (stateQ == ST_DONE);

  always_comb begin
    strb.capture    = missReady && missValid;
    strb.newSector  = missReady && missValid && !missSectorHit;
    strb.burstOn    = memReq;
    strb.selPref    = (stateQ == ST_FILL_PREFETCH);
    strb.doneDemand = (stateQ == ST_FILL_DEMAND) && memAck;
    strb.donePref   = (stateQ == ST_FILL_PREFETCH) && memAck;
  end

  // R10
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq);
  // R9
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !missReady);
  // R3
  fill_after_new_sector_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.newSector |=> memReq && !missReady);
endmodule

// File: rtl/sfs_dpath.sv
module sfs_dpath
  import sfs_pkg::*;
#(
  parameter int LINE_AW = 27
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [LINE_AW-1:0] missLine,
  input  logic               memAck,
  output logic [LINE_AW-1:0] memLine,
  output logic               fillWe,
  output logic               fillLine,
  output logic               validSet,
  output logic               validLine,
  output logic               tagWrite,
  output logic               validClr
);
  localparam int SECT_AW = LINE_AW - 1;

  logic [SECT_AW-1:0] sectQ;
  logic               halfQ;
  logic               validSetQ, validLineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectQ      <= '0;
      halfQ      <= 1'b0;
      validSetQ  <= 1'b0;
      validLineQ <= 1'b0;
    end else begin
      if (strb.capture) begin
        sectQ <= missLine[LINE_AW-1:1];
        halfQ <= missLine[0];
      end
      validSetQ  <= strb.doneDemand || strb.donePref;
      validLineQ <= strb.donePref ? 1'b1 : halfQ;
    end
  end

  assign memLine   = {sectQ, strb.selPref ? 1'b1 : halfQ};
  assign fillWe    = strb.burstOn;
  assign fillLine  = memLine[0];
  assign validSet  = validSetQ;
  assign validLine = validLineQ;
  assign tagWrite  = strb.newSector;
  assign validClr  = strb.newSector;

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillWe && !memAck |=> fillWe && $stable(memLine));
  // R5
  valid_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    validSet |-> $past(fillWe && memAck));
  // R4
  demand_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagWrite |=> fillWe && (fillLine == $past(missLine[0])));
endmodule

// File: rtl/sector_fill_seq.sv
module sector_fill_seq
  import sfs_pkg::*;
#(
  parameter int LINE_AW = 27
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               missValid,
  input  logic [LINE_AW-1:0] missLine,
  input  logic               missSectorHit,
  output logic               missReady,
  output logic               missDone,
  output logic               memReq,
  output logic [LINE_AW-1:0] memLine,
  input  logic               memAck,
  output logic               fillWe,
  output logic               fillLine,
  output logic               validSet,
  output logic               validLine,
  output logic               tagWrite,
  output logic               validClr
);
  seqStrobe_t strb;

  sfs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missSectorHit(missSectorHit),
    .missLineBit(missLine[0]), .memAck(memAck), .strb(strb),
    .missReady(missReady), .memReq(memReq), .missDone(missDone)
  );

  sfs_dpath #(.LINE_AW(LINE_AW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .missLine(missLine), .memAck(memAck),
    .memLine(memLine), .fillWe(fillWe), .fillLine(fillLine), .validSet(validSet),
    .validLine(validLine), .tagWrite(tagWrite), .validClr(validClr)
  );

  // R6
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    missDone |-> validSet);
  // R8
  no_backward_pref_chk: assert property (@(posedge clk) disable iff (!rstN)
    missDone && validLine |=> !memReq);
endmodule

// File: tb/sector_fill_seq_tb_top.sv
module sector_fill_seq_tb_top;
  localparam int LAW = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [LAW-1:0] missLine = '0;
  logic missSectorHit = 1'b0;
  logic memAck = 1'b0;
  logic missReady, missDone, memReq, fillWe, fillLine;
  logic validSet, validLine, tagWrite, validClr;
  logic [LAW-1:0] memLine;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  sector_fill_seq #(.LINE_AW(LAW)) dut_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missLine(missLine),
    .missSectorHit(missSectorHit), .missReady(missReady), .missDone(missDone),
    .memReq(memReq), .memLine(memLine), .memAck(memAck), .fillWe(fillWe),
    .fillLine(fillLine), .validSet(validSet), .validLine(validLine),
    .tagWrite(tagWrite), .validClr(validClr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  // wait some cycles with burst open, then acknowledge; returns after the ack edge
  task automatic ackBurst(input int delay, input logic [LAW-1:0] expLine, input string req);
    for (int i = 0; i < delay; i++) begin
      stepEdge();
      chk(req, "memReq held", memReq, 1);
      chk("R10", "memLine held", memLine, expLine);
      chk("R5", "no validSet before ack", validSet, 0);
    end
    @(negedge clk);
    memAck = 1'b1;
    stepEdge();
    memAck = 1'b0;
    chk("R10", "memReq drops after ack", memReq, 0);
    chk("R5", "validSet after ack", validSet, 1);
  endtask

  task automatic runMiss(input logic [LAW-1:0] ln, input logic hit, input int dDem,
                         input int dPref);
    logic expPref;
    logic [LAW-1:0] prefLine;
    expPref = !hit && !ln[0];
    prefLine = {ln[LAW-1:1], 1'b1};
    @(negedge clk);
    missValid = 1'b1; missLine = ln; missSectorHit = hit;
    #1;
    chk("R9", "missReady idle", missReady, 1);
    chk(hit ? "R2" : "R3", "tagWrite", tagWrite, !hit);
    chk(hit ? "R2" : "R3", "validClr", validClr, !hit);
    chk("R3", "no burst in accept cycle", memReq, 0);
    stepEdge();
    missValid = 1'b0;
    chk("R4", "memReq", memReq, 1);
    chk("R4", "memLine demand", memLine, ln);
    chk("R4", "fillWe", fillWe, 1);
    chk("R4", "fillLine", fillLine, ln[0]);
    chk("R9", "missReady busy", missReady, 0);
    ackBurst(dDem, ln, "R4");
    chk("R5", "validLine demand", validLine, ln[0]);
    chk("R6", "missDone", missDone, 1);
    stepEdge();
    chk("R6", "missDone one cycle", missDone, 0);
    if (expPref) begin
      chk("R7", "prefetch memReq", memReq, 1);
      chk("R7", "prefetch memLine", memLine, prefLine);
      chk("R7", "prefetch fillLine", fillLine, 1);
      chk("R9", "busy during prefetch", missReady, 0);
      ackBurst(dPref, prefLine, "R7");
      chk("R7", "validLine prefetch", validLine, 1);
      chk("R7", "no missDone for prefetch", missDone, 0);
      chk("R9", "ready after prefetch", missReady, 1);
      stepEdge();
    end else begin
      chk(hit ? "R2" : "R8", "no prefetch burst", memReq, 0);
      chk(hit ? "R2" : "R8", "back to idle", missReady, 1);
    end
    chk("R5", "validSet one cycle", validSet, 0);
    chk("R10", "no stray burst", memReq, 0);
  endtask

  task automatic testReset();
    chk("R1", "missReady", missReady, 1);
    chk("R1", "memReq", memReq, 0);
    chk("R1", "fillWe", fillWe, 0);
    chk("R1", "validSet", validSet, 0);
    chk("R1", "missDone", missDone, 0);
    chk("R1", "tagWrite", tagWrite, 0);
    chk("R1", "validClr", validClr, 0);
  endtask

  // a miss raised while a prefetch runs must wait for it
  task automatic testMissDuringPrefetch();
    logic [LAW-1:0] a, b;
    a = 27'h00_0C40;
    b = 27'h00_0C41;
    @(negedge clk);
    missValid = 1'b1; missLine = a; missSectorHit = 1'b0;
    stepEdge();
    missValid = 1'b0;
    ackBurst(1, a, "R4");
    stepEdge();
    chk("R7", "prefetch started", memLine, b);
    @(negedge clk);
    missValid = 1'b1; missLine = b; missSectorHit = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9", "held off during prefetch", missReady, 0);
      chk("R9", "no tagWrite while busy", tagWrite, 0);
      stepEdge();
      chk("R9", "prefetch address kept", memLine, b);
    end
    @(negedge clk);
    memAck = 1'b1;
    stepEdge();
    memAck = 1'b0;
    chk("R9", "prefetch valid first", validSet, 1);
    chk("R9", "prefetch valid line", validLine, 1);
    chk("R9", "ready after prefetch", missReady, 1);
    chk("R2", "held miss is a hit", tagWrite, 0);
    stepEdge();
    missValid = 1'b0;
    chk("R9", "held miss served", memReq, 1);
    chk("R9", "held miss address", memLine, b);
    ackBurst(0, b, "R2");
    chk("R6", "held miss done", missDone, 1);
    stepEdge();
    chk("R2", "no prefetch for hit", memReq, 0);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    runMiss(27'h00_0100, 1'b1, 2, 0);   // R2 hit, lower half
    runMiss(27'h00_0101, 1'b1, 0, 0);   // R2 hit, upper half
    runMiss(27'h00_02A4, 1'b0, 3, 2);   // R7 forward prefetch
    runMiss(27'h00_03B7, 1'b0, 1, 0);   // R8 upper half, no prefetch
    runMiss(27'h7FF_FFFE, 1'b0, 0, 0);  // R7 back-to-back acks
    testMissDuringPrefetch();           // R9
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule